// File: doc/BRIEF.md
# Logarithmic Dissemination Barrier

This block synchronizes a fixed team of hardware threads whose size is a power of two. Each thread raises a one-cycle arrive pulse when it reaches the synchronization point. Later it receives a one-cycle release pulse. No thread is released until every member of the team has arrived for the same episode. There is no central arrival counter and no wide AND across all threads. Instead, each thread runs a short sequence of rounds, one round for each bit of the team size. In every round it exchanges single-bit flags with a partner at a power-of-two distance.

The block holds a matrix of one-bit flags, with one row per round and one column per thread. Beside the matrix sits one small sequencer for each thread. In round i, thread t waits until its partner's flag is clear and then sets it. It then waits for its own flag, which its own signaller sets. When it sees that flag it clears it and moves to the next round. Because a flag is set only when it is clear, a thread that starts the next episode early cannot overwrite a flag that a slower thread has not yet consumed. The barrier can therefore be reused back to back.

Top module: `dissem_barrier`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, every release output is low, every flag is zero and every thread sequencer is idle.
- R2: A thread's release pulse for episode g (its g-th release) never occurs before all NUM_THREADS threads have made their g-th accepted arrival.
- R3: An arrive pulse is accepted when the thread is idle or in its release cycle. A release follows an accepted arrival no sooner than 2·log2(NUM_THREADS)+1 cycles later. If all threads arrive in the same cycle, all release outputs pulse together exactly 2·log2(NUM_THREADS)+1 cycles after that cycle, which is 5 cycles for 4 threads.
- R4: Release is a pulse one cycle wide. Each accepted arrival produces exactly one release and no other release occurs.
- R5: An arrive pulse given while the thread's barrier is in progress (after acceptance and before its release cycle) is ignored. It produces no additional release.
- R6: The barrier runs log2(NUM_THREADS) rounds. In round i, thread t sets the flag of partner (t + 2^i) mod NUM_THREADS, so partner indices wrap around the team.
- R7: A thread sets its partner's round flag only in a cycle in which that flag is clear. No flag is set and cleared in the same cycle. Episodes that overlap, where one thread has re-arrived while others are still finishing, stay correct.
- R8: A flag is cleared only by its owning thread, in the cycle it observes that flag set, and the thread then moves to the next round. A flag never changes without a set or a clear.
- R9: With 4 threads, every thread's release for an episode comes within 32 cycles of the latest arrival of that episode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | NUM_THREADS | One-cycle arrival pulse per thread |
| release_o | output | NUM_THREADS | One-cycle release pulse per thread |

## Verification
The first pattern has every thread arrive in the same cycle, repeated back to back. It pins down the exact release latency and shows that each flag is consumed before the next episode. The second pattern sweeps all 24 arrival orders of four threads with spaced delays, so that every thread in turn is the straggler whose flags must cross the wrap-around. This separates a correct partner mapping from one that releases early or deadlocks. The third pattern uses independent random delays from zero upward, with immediate re-arrival. It makes episodes overlap and tests whether a leftover flag is ever overwritten. A final pattern injects a stray arrive pulse mid-barrier to show it is ignored.

// File: rtl/dbar_pkg.sv
package dbar_pkg;
   typedef enum logic [1:0] {
      TS_IDLE = 2'd0,
      TS_SEND = 2'd1,
      TS_WAIT = 2'd2,
      TS_FIRE = 2'd3
   } tstate_e;
endpackage

// File: rtl/dbar_flag_bank.sv
module dbar_flag_bank #(
   parameter int ROUNDS = 2,
   parameter int NP     = 4,
   localparam int NFLAG = ROUNDS * NP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flag_o
);
   // one register row per round; set and clear are exclusive by protocol
   for (genvar r = 0; r < ROUNDS; r++) begin : g_row
      logic [NP-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n) row_q <= '0;
         else        row_q <= (row_q | set_i[r*NP +: NP]) & ~clr_i[r*NP +: NP];
      end
      assign flag_o[r*NP +: NP] = row_q;
   end
endmodule

// File: rtl/dbar_thread_seq.sv
module dbar_thread_seq
   import dbar_pkg::*;
#(
   parameter int ROUNDS = 2,
   localparam int RNDW  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arrive_i,
   input  logic [ROUNDS-1:0] partner_flag_i,
   input  logic [ROUNDS-1:0] own_flag_i,
   output logic [ROUNDS-1:0] set_o,
   output logic [ROUNDS-1:0] clr_o,
   output logic              release_o
);
   localparam logic [RNDW-1:0] LAST = RNDW'(ROUNDS - 1);

   tstate_e         state;
   logic [RNDW-1:0] rnd;
   logic            sent, seen;

   always_comb begin
      set_o = '0;
      clr_o = '0;
      for (int i = 0; i < ROUNDS; i++) begin
         if (state == TS_SEND && rnd == RNDW'(i) && !partner_flag_i[i]) set_o[i] = 1'b1;
         if (state == TS_WAIT && rnd == RNDW'(i) &&  own_flag_i[i])     clr_o[i] = 1'b1;
      end
   end

   assign sent      = |set_o;
   assign seen      = |clr_o;
   assign release_o = (state == TS_FIRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TS_IDLE;
         rnd   <= '0;
      end else begin
         case (state)
            TS_IDLE, TS_FIRE: begin
               if (arrive_i) begin
                  state <= TS_SEND;
                  rnd   <= '0;
               end else begin
                  state <= TS_IDLE;
               end
            end
            TS_SEND: if (sent) state <= TS_WAIT;
            TS_WAIT: begin
               if (seen) begin
                  if (rnd == LAST) begin
                     state <= TS_FIRE;
                  end else begin
                     rnd   <= rnd + 1'b1;
                     state <= TS_SEND;
                  end
               end
            end
            default: state <= TS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dissem_barrier.sv
module dissem_barrier #(
   parameter int NUM_THREADS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] arrive_i,
   output logic [NUM_THREADS-1:0] release_o
);
   localparam int NP     = NUM_THREADS;
   localparam int ROUNDS = $clog2(NP);
   localparam int NFLAG  = ROUNDS * NP;

   if (NP < 2 || (NP & (NP - 1)) != 0) begin : g_bad_np
      $error("dissem_barrier: NUM_THREADS must be a power of two, at least 2");
   end

   logic [NFLAG-1:0]  flag_q, set_all, clr_all;
   logic [ROUNDS-1:0] th_pf  [NP];
   logic [ROUNDS-1:0] th_of  [NP];
   logic [ROUNDS-1:0] th_set [NP];
   logic [ROUNDS-1:0] th_clr [NP];

   // per-thread views of the matrix: partner column wraps modulo NP
   always_comb begin
      for (int t = 0; t < NP; t++) begin
         for (int i = 0; i < ROUNDS; i++) begin
            th_pf[t][i] = flag_q[i*NP + ((t + (1 << i)) % NP)];
            th_of[t][i] = flag_q[i*NP + t];
         end
      end
   end

   // flag (round i, column p) is set by its single signaller (p - 2^i) mod NP
   always_comb begin
      set_all = '0;
      clr_all = '0;
      for (int i = 0; i < ROUNDS; i++) begin
         for (int p = 0; p < NP; p++) begin
            set_all[i*NP + p] = th_set[(p + NP - (1 << i)) % NP][i];
            clr_all[i*NP + p] = th_clr[p][i];
         end
      end
   end

   dbar_flag_bank #(.ROUNDS(ROUNDS), .NP(NP)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_all),
      .clr_i  (clr_all),
      .flag_o (flag_q)
   );

   for (genvar t = 0; t < NP; t++) begin : g_thr
      dbar_thread_seq #(.ROUNDS(ROUNDS)) u_seq (
         .clk            (clk),
         .rst_n          (rst_n),
         .arrive_i       (arrive_i[t]),
         .partner_flag_i (th_pf[t]),
         .own_flag_i     (th_of[t]),
         .set_o          (th_set[t]),
         .clr_o          (th_clr[t]),
         .release_o      (release_o[t])
      );
   end
endmodule

// File: rtl/dbar_chk.sv
module dbar_chk #(
   parameter int NP    = 4,
   parameter int NFLAG = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NP-1:0]    release_o,
   input logic [NFLAG-1:0] flag_q,
   input logic [NFLAG-1:0] flag_set,
   input logic [NFLAG-1:0] flag_clr
);
   p_rst_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (flag_q == '0 && release_o == '0));

   p_no_set_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set & flag_clr) == '0);

   p_set_when_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set & flag_q) == '0);

   p_clr_when_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & ~flag_q) == '0);

   p_rise_by_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

   p_fall_by_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr == '0) |=> ((~flag_q & $past(flag_q)) == '0));

   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (release_o != '0) |=> ((release_o & $past(release_o)) == '0));
endmodule

bind dissem_barrier dbar_chk #(.NP(NP), .NFLAG(NFLAG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .release_o (release_o),
   .flag_q    (flag_q),
   .flag_set  (set_all),
   .flag_clr  (clr_all)
);

// File: tb/sim_dissem_barrier.sv
module sim_dissem_barrier;
   localparam int NP    = 4;
   localparam int RND   = 2;
   localparam int LAT   = 2 * RND + 1;
   localparam int BOUND = 32;
   localparam int MAXG  = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] arrive = '0;
   logic [NP-1:0] rel;

   always #10 clk = ~clk;   // 50 MHz

   dissem_barrier #(.NUM_THREADS(NP)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive_i  (arrive),
      .release_o (rel)
   );

   int    checks = 0, fails = 0, cyc = 0;
   bit    timeout = 0;
   int    cnt_arr [NP], cnt_rel [NP], cdown [NP], arr_cyc [NP], rel_cyc [NP];
   bit    busy [NP];
   int    gen_last [MAXG];
   int    target = 0, mode = 0, extra_t = -1, extra_cyc = 0;
   string rtag = "R2";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int next_delay();
      if (mode == 0) return 0;
      return int'($urandom_range(0, 7));
   endfunction

   task automatic step();
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !timeout) begin
         timeout = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      end
      for (int t = 0; t < NP; t++) begin
         if (rel[t]) begin
            if (!busy[t]) begin
               check(1'b0, "R4", "release without pending arrival", 1, 0);
            end else begin
               int g  = cnt_rel[t] + 1;
               int mn = cnt_arr[0];
               for (int k = 1; k < NP; k++) if (cnt_arr[k] < mn) mn = cnt_arr[k];
               check(mn >= g, rtag, "arrivals complete before release", mn, g);
               check(cyc - arr_cyc[t] >= LAT, "R3", "minimum latency", cyc - arr_cyc[t], LAT);
               check(cyc - gen_last[g] <= BOUND, "R9", "release after last arrival",
                     cyc - gen_last[g], BOUND);
               busy[t]    = 1'b0;
               cnt_rel[t] = g;
               rel_cyc[t] = cyc;
               cdown[t]   = next_delay();
            end
         end
      end
      arrive = '0;
      for (int t = 0; t < NP; t++) begin
         if (!busy[t] && cnt_arr[t] < target) begin
            if (cdown[t] == 0) begin
               arrive[t]  = 1'b1;
               busy[t]    = 1'b1;
               cnt_arr[t] = cnt_arr[t] + 1;
               arr_cyc[t] = cyc;
               gen_last[cnt_arr[t]] = cyc;
            end else begin
               cdown[t] = cdown[t] - 1;
            end
         end
      end
      if (extra_t >= 0 && cyc == extra_cyc) arrive[extra_t] = 1'b1;
   endtask

   task automatic run_phase();
      bit done;
      done = 1'b0;
      while (!done && !timeout) begin
         step();
         done = 1'b1;
         for (int t = 0; t < NP; t++) if (cnt_rel[t] != target) done = 1'b0;
      end
   endtask

   initial begin
      for (int t = 0; t < NP; t++) begin
         cnt_arr[t] = 0; cnt_rel[t] = 0; cdown[t] = 0;
         arr_cyc[t] = 0; rel_cyc[t] = 0; busy[t] = 1'b0;
      end
      for (int g = 0; g < MAXG; g++) gen_last[g] = 0;

      // R1: reset state
      repeat (3) step();
      check(rel == '0, "R1", "release during reset", int'(rel), 0);
      rst_n = 1'b1;
      step();
      check(rel == '0, "R1", "release right after reset", int'(rel), 0);
      repeat (3) step();
      check(rel == '0, "R1", "release while idle", int'(rel), 0);

      // R3 / R8: simultaneous arrival, repeated back to back
      mode = 0;
      rtag = "R8";
      for (int rep = 0; rep < 3; rep++) begin
         for (int t = 0; t < NP; t++) cdown[t] = 0;
         target++;
         run_phase();
         for (int t = 0; t < NP; t++) begin
            check(rel_cyc[t] - arr_cyc[t] == LAT, "R3", "exact latency, all together",
                  rel_cyc[t] - arr_cyc[t], LAT);
            check(rel_cyc[t] == rel_cyc[0], "R3", "joint release cycle", rel_cyc[t], rel_cyc[0]);
         end
      end

      // R6: every arrival order, straggler moves around the team
      rtag = "R6";
      for (int a = 0; a < NP; a++)
         for (int b = 0; b < NP; b++)
            for (int c = 0; c < NP; c++)
               for (int d = 0; d < NP; d++) begin
                  if (a != b && a != c && a != d && b != c && b != d && c != d && !timeout) begin
                     cdown[a] = 0; cdown[b] = 3; cdown[c] = 6; cdown[d] = 9;
                     target++;
                     run_phase();
                     for (int t = 0; t < NP; t++)
                        check(cnt_rel[t] == target, "R6", "release count after order",
                              cnt_rel[t], target);
                  end
               end

      // R7: random delays, immediate re-arrival, overlapping episodes
      mode = 1;
      rtag = "R7";
      for (int t = 0; t < NP; t++) cdown[t] = next_delay();
      target += 150;
      run_phase();
      for (int t = 0; t < NP; t++)
         check(cnt_rel[t] == target, "R4", "one release per arrival", cnt_rel[t], target);

      // R5: stray arrive pulse while barrier is in progress
      mode = 0;
      rtag = "R2";
      cdown[0] = 0; cdown[1] = 10; cdown[2] = 10; cdown[3] = 10;
      extra_t   = 0;
      extra_cyc = cyc + 4;
      target++;
      run_phase();
      extra_t = -1;
      check(cnt_rel[0] == target, "R5", "releases with stray pulse", cnt_rel[0], target);
      repeat (40) step();
      check(cnt_rel[0] == target, "R5", "no late extra release", cnt_rel[0], target);
      check(rel == '0, "R5", "idle after barrier", int'(rel), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule